// File: doc/BRIEF.md
# Block-Buffered Pseudo-DMA Controller

This block connects a host memory-mapped port to a byte-wide transfer engine through a single 128-byte staging buffer. The host uses two addresses. One address is the data port, which reads or writes the buffer. The other address loads an 8-bit block counter. A not-ready status flag tells the host when the buffer belongs to the engine side. A host pointer and an engine pointer each walk the buffer. When the engine has moved a whole block, both pointers return to zero and the buffer goes back to the host.

The direction control picks the data flow:
- **Send:** the host fills the buffer and the engine drains it.
- **Receive:** the engine fills the buffer and the host drains it.

Engine traffic runs only when all three of these hold:
- the count has been loaded;
- the DMA enable is high;
- a start strobe of the matching kind has been given.

Each block completion decrements the count modulo 256. When the count reaches zero, the block stops, raises an end-of-DMA flag and, if enabled, an interrupt.

Top module: `blkdma_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the following are all 0: `sts_not_ready`, `sts_blk_loaded`, `blk_count`, `sts_dma_end`, `sts_last_sent`, `irq` and `eng_req`.
- R2: `hst_rdata` shows 0xFF whenever `cfg_dir_rd` is 0 (host-write direction) or the host pointer equals 128. Otherwise it shows the buffer byte at the host pointer.
- R3: With `cfg_dir_rd`=0, a data-port write (`hst_addr`=0) stores the byte and advances the host pointer, but only while the pointer is below 128. The write that brings the pointer to 128 sets `sts_not_ready`. Later data writes have no effect.
- R4: A write with `hst_addr`=1 loads `blk_count` from `hst_wdata` and sets `sts_blk_loaded`. With `cfg_dir_rd`=1 it also moves the host pointer to 128 and sets `sts_not_ready`. A load takes precedence over a same-cycle block completion.
- R5: `eng_req` is high only when all of these hold: the count is loaded, `cfg_dma_en`=1, `sts_not_ready`=1, and the last start strobe matches the direction. The send strobe matches `cfg_dir_rd`=0 and the receive strobe matches `cfg_dir_rd`=1.
- R6: In send, `eng_wdata` presents the buffer bytes in order from index 0 to index 127. Each cycle with `eng_req` and `eng_ack` both high consumes one byte.
- R7: In receive, each cycle with `eng_req` and `eng_ack` both high stores `eng_rdata` at the next buffer index. The host later reads these bytes back in the same order.
- R8: The 128th engine byte of a block does four things: it returns both pointers to 0, clears `sts_not_ready`, decrements `blk_count` modulo 256 (0 becomes 255) and keeps the transfer going unless the count became 0.
- R9: When a block completion leaves the count at 0, the block clears `sts_blk_loaded`, sets `sts_dma_end` and stops requesting. It sets `irq` only if `cfg_eop_irq_en` is 1.
- R10: A send transfer ending at count 0 sets `sts_last_sent`. A receive transfer leaves `sts_last_sent` clear.
- R11: With `cfg_dir_rd`=1, each data-port read below index 128 advances the host pointer. The read that brings the pointer to 128 sets `sts_not_ready`, which hands the buffer to the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_addr | input | 1 | 0 selects the data port, 1 selects the block counter |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe (advances the pointer) |
| hst_wdata | input | DATA_W | Host write data |
| hst_rdata | output | DATA_W | Data-port read value |
| cfg_dir_rd | input | 1 | 1 = receive (host reads), 0 = send (host writes) |
| cfg_dma_en | input | 1 | DMA mode enable |
| cfg_eop_irq_en | input | 1 | End-of-process interrupt enable |
| start_send | input | 1 | Arm a send transfer (pulse) |
| start_recv | input | 1 | Arm a receive transfer (pulse) |
| eng_req | output | 1 | Engine byte request |
| eng_ack | input | 1 | Engine byte acknowledge |
| eng_wdata | output | DATA_W | Byte offered to the engine in send |
| eng_rdata | input | DATA_W | Byte supplied by the engine in receive |
| sts_not_ready | output | 1 | Buffer owned by the engine side |
| sts_blk_loaded | output | 1 | Block count loaded and not yet exhausted |
| sts_dma_end | output | 1 | Transfer finished (sticky) |
| sts_last_sent | output | 1 | Send transfer finished (sticky) |
| blk_count | output | CNT_W | Remaining block count |
| irq | output | 1 | End-of-process interrupt (sticky) |

## Verification
Every flag, the count and both pointers change at the rising edge that samples the strobe or the acknowledge. Their new values are visible in the cycle after that stimulus. `eng_req`, `hst_rdata` and `eng_wdata` are combinational from that state and from the direction input, so they follow in the same cycle as a direction change. The bench drives inputs just after the falling edge. It compares every output against a behavioural model one time unit later, and the model advances on the rising edge. Each comparison therefore sees exactly the state left by the previous edge together with the current inputs. Directed checks at the block boundaries and after completion use the same sampling point.

// File: rtl/blkdma_pkg.sv
// Shared constants and types for the block-buffered pseudo-DMA controller.
// Assumes one buffer shared by host and engine; no clock crossing.
package blkdma_pkg;
    localparam int DEF_DATA_W    = 8;
    localparam int DEF_BLK_BYTES = 128;
    localparam int DEF_CNT_W     = 8;

    // Transfer kind armed by the start strobes.
    typedef enum logic [1:0] {
        XM_IDLE = 2'd0,
        XM_SEND = 2'd1,
        XM_RECV = 2'd2
    } xfer_mode_e;
endpackage

// File: rtl/blkdma_buf.sv
// Staging buffer: one write port, two asynchronous read ports.
// Assumes the caller arbitrates the single write port.
module blkdma_buf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store one byte per cycle.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read ports are combinational.
    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/blkdma_host.sv
// Host-side pointer: data-port writes in send, reads in receive,
// read-data masking and the pointer-full pulse.
// Assumes a count load outranks an engine wrap, which outranks host access.
module blkdma_host #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    localparam int PW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_rd,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic              cnt_load,
    input  logic              eng_wrap,
    input  logic [DATA_W-1:0] buf_byte,
    output logic [PW-1:0]     ptr,
    output logic              buf_we,
    output logic              fill_done,
    output logic [DATA_W-1:0] rdata
);
    logic at_end;
    logic adv;

    // Pointer position and access qualification.
    always_comb begin
        at_end    = (ptr == PW'(DEPTH));
        buf_we    = wr_stb & ~dir_rd & ~at_end;
        adv       = buf_we | (rd_stb & dir_rd & ~at_end);
        fill_done = adv & (ptr == PW'(DEPTH - 1));
        rdata     = (~dir_rd | at_end) ? {DATA_W{1'b1}} : buf_byte;
    end

    // Host pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ptr <= '0;
        else if (cnt_load & dir_rd) ptr <= PW'(DEPTH);
        else if (eng_wrap)          ptr <= '0;
        else if (adv)               ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/blkdma_engine.sv
// Engine-side sequencer: armed mode, byte request, engine pointer, block wrap.
// Assumes the top supplies 'stop' on the wrap that exhausts the count.
module blkdma_engine
    import blkdma_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_send,
    input  logic       start_recv,
    input  logic       stop,
    input  logic       dma_en,
    input  logic       loaded,
    input  logic       not_ready,
    input  logic       dir_rd,
    input  logic       ack,
    output logic       req,
    output logic       wrap,
    output logic       buf_we,
    output logic [AW-1:0] ptr,
    output xfer_mode_e mode
);
    logic dir_ok;
    logic beat;

    // Request gating and byte beat.
    always_comb begin
        dir_ok = ((mode == XM_SEND) & ~dir_rd) | ((mode == XM_RECV) & dir_rd);
        req    = loaded & dma_en & not_ready & dir_ok;
        beat   = req & ack;
        wrap   = beat & (ptr == AW'(DEPTH - 1));
        buf_we = beat & (mode == XM_RECV);
    end

    // Armed transfer kind.
    always_ff @(posedge clk) begin
        if (!rst_n)          mode <= XM_IDLE;
        else if (start_send) mode <= XM_SEND;
        else if (start_recv) mode <= XM_RECV;
        else if (stop)       mode <= XM_IDLE;
    end

    // Engine pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (wrap) ptr <= '0;
        else if (beat) ptr <= ptr + 1'b1;
    end
endmodule

// File: rtl/blkdma_ctrl.sv
// Top of the pseudo-DMA controller: block counter, status flags, interrupt,
// buffer write arbitration. Assumes host writes and engine writes never
// coincide (they belong to opposite directions).
module blkdma_ctrl
    import blkdma_pkg::*;
#(
    parameter int DATA_W    = DEF_DATA_W,
    parameter int BLK_BYTES = DEF_BLK_BYTES,
    parameter int CNT_W     = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_addr,
    input  logic              hst_wr,
    input  logic              hst_rd,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    input  logic              cfg_dir_rd,
    input  logic              cfg_dma_en,
    input  logic              cfg_eop_irq_en,
    input  logic              start_send,
    input  logic              start_recv,
    output logic              eng_req,
    input  logic              eng_ack,
    output logic [DATA_W-1:0] eng_wdata,
    input  logic [DATA_W-1:0] eng_rdata,
    output logic              sts_not_ready,
    output logic              sts_blk_loaded,
    output logic              sts_dma_end,
    output logic              sts_last_sent,
    output logic [CNT_W-1:0]  blk_count,
    output logic              irq
);
    localparam int AW = $clog2(BLK_BYTES);
    localparam int PW = $clog2(BLK_BYTES + 1);

    logic              cnt_load, data_wr, data_rd;
    logic [PW-1:0]     host_ptr;
    logic [AW-1:0]     eng_ptr;
    logic              host_we, eng_we, fill_done, eng_wrap, finish;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [DATA_W-1:0] mem_wdata, host_byte;
    xfer_mode_e        eng_mode;

    // Decode host strobes and the exhausting wrap.
    always_comb begin
        cnt_load = hst_wr & hst_addr;
        data_wr  = hst_wr & ~hst_addr;
        data_rd  = hst_rd & ~hst_addr;
        finish   = eng_wrap & (blk_count == CNT_W'(1));
    end

    // Buffer write arbitration: engine fills in receive, host in send.
    always_comb begin
        mem_we    = host_we | eng_we;
        mem_waddr = eng_we ? eng_ptr   : host_ptr[AW-1:0];
        mem_wdata = eng_we ? eng_rdata : hst_wdata;
    end

    blkdma_buf #(.DATA_W(DATA_W), .DEPTH(BLK_BYTES)) u_buf (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (host_ptr[AW-1:0]),
        .rdata_a (host_byte),
        .raddr_b (eng_ptr),
        .rdata_b (eng_wdata)
    );

    blkdma_host #(.DATA_W(DATA_W), .DEPTH(BLK_BYTES)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_rd    (cfg_dir_rd),
        .wr_stb    (data_wr),
        .rd_stb    (data_rd),
        .cnt_load  (cnt_load),
        .eng_wrap  (eng_wrap),
        .buf_byte  (host_byte),
        .ptr       (host_ptr),
        .buf_we    (host_we),
        .fill_done (fill_done),
        .rdata     (hst_rdata)
    );

    blkdma_engine #(.DEPTH(BLK_BYTES)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_send (start_send),
        .start_recv (start_recv),
        .stop       (finish),
        .dma_en     (cfg_dma_en),
        .loaded     (sts_blk_loaded),
        .not_ready  (sts_not_ready),
        .dir_rd     (cfg_dir_rd),
        .ack        (eng_ack),
        .req        (eng_req),
        .wrap       (eng_wrap),
        .buf_we     (eng_we),
        .ptr        (eng_ptr),
        .mode       (eng_mode)
    );

    // Block counter and loaded flag; a load outranks a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_count      <= '0;
            sts_blk_loaded <= 1'b0;
        end else if (cnt_load) begin
            blk_count      <= CNT_W'(hst_wdata);
            sts_blk_loaded <= 1'b1;
        end else if (eng_wrap) begin
            blk_count      <= blk_count - 1'b1;
            if (finish) sts_blk_loaded <= 1'b0;
        end
    end

    // Buffer ownership flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                     sts_not_ready <= 1'b0;
        else if (cnt_load & cfg_dir_rd) sts_not_ready <= 1'b1;
        else if (eng_wrap)              sts_not_ready <= 1'b0;
        else if (fill_done)             sts_not_ready <= 1'b1;
    end

    // Sticky completion flags and interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_dma_end   <= 1'b0;
            sts_last_sent <= 1'b0;
            irq           <= 1'b0;
        end else if (finish & ~cnt_load) begin
            sts_dma_end <= 1'b1;
            if (eng_mode == XM_SEND) sts_last_sent <= 1'b1;
            if (cfg_eop_irq_en)      irq           <= 1'b1;
        end
    end
endmodule

// File: rtl/blkdma_ctrl_chk.sv
// Assertion checker for blkdma_ctrl, attached by bind below.
module blkdma_ctrl_chk #(
    parameter int DATA_W    = 8,
    parameter int BLK_BYTES = 128,
    parameter int CNT_W     = 8,
    localparam int AW       = $clog2(BLK_BYTES),
    localparam int PW       = $clog2(BLK_BYTES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hst_addr,
    input logic              hst_wr,
    input logic [DATA_W-1:0] hst_wdata,
    input logic [DATA_W-1:0] hst_rdata,
    input logic              cfg_dir_rd,
    input logic              cfg_dma_en,
    input logic              cfg_eop_irq_en,
    input logic              eng_req,
    input logic              eng_ack,
    input logic              sts_not_ready,
    input logic              sts_blk_loaded,
    input logic              sts_dma_end,
    input logic              sts_last_sent,
    input logic [CNT_W-1:0]  blk_count,
    input logic              irq,
    input logic [PW-1:0]     host_ptr,
    input logic [AW-1:0]     eng_ptr
);
    logic last_beat, load_now;
    assign last_beat = eng_req & eng_ack & (eng_ptr == AW'(BLK_BYTES - 1));
    assign load_now  = hst_wr & hst_addr;

    a_r5_req_gate: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> (sts_not_ready && sts_blk_loaded && cfg_dma_en));

    a_r2_ff_send_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_dir_rd |-> (hst_rdata == {DATA_W{1'b1}}));

    a_r3_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        host_ptr <= PW'(BLK_BYTES));

    a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_now |=> (sts_blk_loaded && blk_count == CNT_W'($past(hst_wdata))));

    a_r4_load_rd_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (load_now && cfg_dir_rd) |=> sts_not_ready);

    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !load_now) |=> (!sts_not_ready && blk_count == CNT_W'($past(blk_count) - 1'b1)));

    a_r9_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && !load_now && blk_count == CNT_W'(1)) |=> (sts_dma_end && !sts_blk_loaded));

    a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cfg_eop_irq_en));

    a_r10_last_with_end: assert property (@(posedge clk) disable iff (!rst_n)
        sts_last_sent |-> sts_dma_end);
endmodule

bind blkdma_ctrl blkdma_ctrl_chk #(
    .DATA_W(DATA_W), .BLK_BYTES(BLK_BYTES), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .cfg_dir_rd(cfg_dir_rd),
    .cfg_dma_en(cfg_dma_en), .cfg_eop_irq_en(cfg_eop_irq_en),
    .eng_req(eng_req), .eng_ack(eng_ack), .sts_not_ready(sts_not_ready),
    .sts_blk_loaded(sts_blk_loaded), .sts_dma_end(sts_dma_end),
    .sts_last_sent(sts_last_sent), .blk_count(blk_count), .irq(irq),
    .host_ptr(host_ptr), .eng_ptr(eng_ptr)
);

// File: tb/tb_blkdma_ctrl.sv
// Bench: behavioural reference model compared on every cycle plus directed checks.
module tb_blkdma_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int BLK = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hst_addr = 0, hst_wr = 0, hst_rd = 0;
    logic [7:0] hst_wdata = 0;
    logic cfg_dir_rd = 0, cfg_dma_en = 0, cfg_eop_irq_en = 0;
    logic start_send = 0, start_recv = 0, eng_ack = 0;
    logic [7:0] eng_rdata = 0;
    logic [7:0] hst_rdata, eng_wdata, blk_count;
    logic eng_req, sts_not_ready, sts_blk_loaded, sts_dma_end, sts_last_sent, irq;

    int checks = 0, errors = 0, cyc = 0, src = 0;

    // Reference model state.
    int  mbuf [BLK];
    bit  mwr  [BLK];
    int  mh = 0, me = 0, mcnt = 0, mmode = 0;
    bit  mloaded = 0, mnr = 0, mend = 0, mlast = 0, mirq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blkdma_ctrl dut (
        .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .cfg_dir_rd(cfg_dir_rd),
        .cfg_dma_en(cfg_dma_en), .cfg_eop_irq_en(cfg_eop_irq_en),
        .start_send(start_send), .start_recv(start_recv), .eng_req(eng_req),
        .eng_ack(eng_ack), .eng_wdata(eng_wdata), .eng_rdata(eng_rdata),
        .sts_not_ready(sts_not_ready), .sts_blk_loaded(sts_blk_loaded),
        .sts_dma_end(sts_dma_end), .sts_last_sent(sts_last_sent),
        .blk_count(blk_count), .irq(irq)
    );

    function automatic bit mreq();
        return mloaded && cfg_dma_en && mnr &&
               ((mmode == 1 && !cfg_dir_rd) || (mmode == 2 && cfg_dir_rd));
    endfunction

    // Model advances on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            mh = 0; me = 0; mcnt = 0; mmode = 0;
            mloaded = 0; mnr = 0; mend = 0; mlast = 0; mirq = 0;
        end else begin
            bit oreq;
            oreq = mreq();
            if (hst_wr && !hst_addr && !cfg_dir_rd && mh < BLK) begin
                mbuf[mh] = hst_wdata; mwr[mh] = 1; mh++;
                if (mh == BLK) mnr = 1;
            end
            if (hst_rd && !hst_addr && cfg_dir_rd && mh < BLK) begin
                mh++;
                if (mh == BLK) mnr = 1;
            end
            if (oreq && eng_ack) begin
                if (mmode == 2) begin mbuf[me] = eng_rdata; mwr[me] = 1; end
                me++;
                if (me == BLK) begin
                    me = 0; mh = 0; mnr = 0; mcnt = (mcnt - 1) & 255;
                    if (mcnt == 0 && !(hst_wr && hst_addr)) begin
                        mloaded = 0; mend = 1;
                        if (mmode == 1) mlast = 1;
                        if (cfg_eop_irq_en) mirq = 1;
                        mmode = 0;
                    end else if (mcnt == 0) mmode = 0;
                end
            end
            if (start_send) mmode = 1;
            else if (start_recv) mmode = 2;
            if (hst_wr && hst_addr) begin
                mcnt = hst_wdata; mloaded = 1;
                if (cfg_dir_rd) begin mh = BLK; mnr = 1; end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Full comparison of every output against the model.
    task automatic compare();
        int exp_rd;
        chk(sts_not_ready === mnr, "R3 not_ready", sts_not_ready, mnr);
        chk(sts_blk_loaded === mloaded, "R4 blk_loaded", sts_blk_loaded, mloaded);
        chk(blk_count === 8'(mcnt), "R8 blk_count", blk_count, mcnt);
        chk(sts_dma_end === mend, "R9 dma_end", sts_dma_end, mend);
        chk(irq === mirq, "R9 irq", irq, mirq);
        chk(sts_last_sent === mlast, "R10 last_sent", sts_last_sent, mlast);
        chk(eng_req === mreq(), "R5 eng_req", eng_req, mreq());
        if (!cfg_dir_rd || mh == BLK) exp_rd = 255;
        else exp_rd = mwr[mh] ? mbuf[mh] : -1;
        if (exp_rd >= 0) chk(hst_rdata === 8'(exp_rd), "R2 hst_rdata", hst_rdata, exp_rd);
        if (mreq() && mmode == 1)
            chk(eng_wdata === 8'(mbuf[me]), "R6 eng_wdata", eng_wdata, mbuf[me]);
    endtask

    // Compare after the inputs settle, then move to the next falling edge.
    task automatic step();
        #1;
        if (rst_n) compare();
        @(negedge clk);
        hst_wr = 0; hst_rd = 0; start_send = 0; start_recv = 0; eng_ack = 0;
    endtask

    task automatic host_write(input logic a, input logic [7:0] d);
        hst_addr = a; hst_wr = 1; hst_wdata = d; step();
    endtask

    task automatic do_reset();
        rst_n = 0; repeat (2) step(); rst_n = 1;
    endtask

    // Drive the engine until its block or the whole transfer finishes.
    task automatic run_engine(input bit until_end);
        int k = 0;
        while ((until_end ? !mend : mnr) && k < 4000) begin
            eng_ack   = mreq() && (k % 3 != 2);
            eng_rdata = 8'((src * 7 + 5) & 255);
            if (eng_ack && mmode == 2) src++;
            k++;
            step();
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        #1;
        // R1: reset state.
        chk(!sts_not_ready && !sts_blk_loaded && blk_count == 0 && !sts_dma_end
            && !sts_last_sent && !irq && !eng_req, "R1 reset state", 0, 0);
        step();

        // Send, two blocks, interrupt enabled.
        cfg_dir_rd = 0; cfg_eop_irq_en = 1; cfg_dma_en = 1;
        hst_addr = 0; hst_rd = 1; #1;
        chk(hst_rdata == 8'hFF, "R2 read in send dir", hst_rdata, 255);
        step();
        for (int i = 0; i < BLK; i++) host_write(0, 8'(i * 3 + 1));
        #1 chk(sts_not_ready == 1, "R3 full sets not_ready", sts_not_ready, 1);
        host_write(0, 8'hEE);                // ignored write
        start_recv = 1; step();              // wrong kind for send direction
        host_write(1, 8'd2);
        repeat (3) step();
        #1 chk(eng_req == 0, "R5 no req on mismatched start", eng_req, 0);
        start_send = 1; step();
        #1 chk(eng_req == 1, "R5 req after matching start", eng_req, 1);
        chk(eng_wdata == 8'd1, "R6 first byte, R3 extra write ignored", eng_wdata, 1);
        run_engine(0);
        #1 chk(blk_count == 1 && !sts_not_ready, "R8 block wrap", blk_count, 1);
        for (int i = 0; i < BLK; i++) host_write(0, 8'(i ^ 8'h5A));
        run_engine(1);
        #1 chk(sts_dma_end && !sts_blk_loaded && irq, "R9 end with irq", irq, 1);
        chk(sts_last_sent == 1, "R10 last_sent after send", sts_last_sent, 1);
        step();

        // Receive, one block, interrupt disabled.
        do_reset();
        cfg_dir_rd = 1; cfg_eop_irq_en = 0; cfg_dma_en = 0; src = 0;
        host_write(1, 8'd1);
        #1 chk(sts_not_ready && sts_blk_loaded && hst_rdata == 8'hFF, "R4 load in read dir",
               hst_rdata, 255);
        start_recv = 1; step();
        repeat (3) step();
        #1 chk(eng_req == 0, "R5 no req while dma disabled", eng_req, 0);
        cfg_dma_en = 1; step();
        run_engine(1);
        #1 chk(sts_dma_end && !irq, "R9 end without irq", irq, 0);
        chk(sts_last_sent == 0, "R10 no last_sent on receive", sts_last_sent, 1'b0);
        for (int i = 0; i < BLK; i++) begin
            hst_addr = 0; hst_rd = 1; #1;
            chk(hst_rdata == 8'((i * 7 + 5) & 255), "R7 received byte order",
                hst_rdata, (i * 7 + 5) & 255);
            step();
        end
        #1 chk(sts_not_ready == 1, "R11 drained buffer sets not_ready", sts_not_ready, 1);
        chk(hst_rdata == 8'hFF, "R2 read at pointer end", hst_rdata, 255);
        step();

        // Count of zero wraps to 255 and keeps going.
        do_reset();
        cfg_dir_rd = 0; cfg_dma_en = 1;
        for (int i = 0; i < BLK; i++) host_write(0, 8'(255 - i));
        host_write(1, 8'd0);
        start_send = 1; step();
        run_engine(0);
        #1 chk(blk_count == 8'd255 && sts_blk_loaded && !sts_dma_end, "R8 modulo-256 wrap",
               blk_count, 255);
        step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule